// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block is the receive half of an asynchronous serial port. It samples one serial input line on every tick of a receive clock. Each bit lasts a number of ticks set by a programmable rate factor. The block finds the falling edge of a start bit and confirms that the start bit is real at its mid point. It then collects the data bits, an optional parity bit and a stop bit, and places the character in a one-entry receive buffer for a host to read.

The host sees a ready flag while a character waits in the buffer, and a one-tick read strobe clears it. Three error flags are kept. Each stays set until the host pulses an error-clear input:

- parity mismatch
- bad stop bit
- character lost because the buffer was not read in time

A separate break output rises when the line stays low through the stop positions of two characters in a row. It falls as soon as the line is seen high again.

Top module: `async_rx_brk`

## Requirements
- R1: While reset is asserted and after it is released, `rx_ready`, `err_parity`, `err_frame`, `err_overrun` and `brk_det` are 0 until a character is received.
- R2: `fac_sel` picks the bit length in receive-clock ticks as 4 shifted left by `fac_sel`, so codes 0, 1, 2 and 3 give 4, 8, 16 and 32 ticks. Every bit is sampled near its middle, measured from the detected falling edge of the start bit.
- R3: `len_sel` sets the number of data bits to 5 + `len_sel`. Data bits arrive least significant bit first, and `rx_data` bits at and above that count read as 0.
- R4: When `par_en` is 1, one parity bit follows the data. With `par_odd` = 0 the data bits plus the parity bit must hold an even count of ones, and with `par_odd` = 1 an odd count. A mismatch sets `err_parity`.
- R5: A stop bit sampled low sets `err_frame`. The character is still placed in the buffer.
- R6: `rx_ready` rises when a character is placed in the buffer. It falls on the tick after `rd_strobe` is sampled high.
- R7: If a character completes while `rx_ready` is still 1 and no read is strobed in that tick, `err_overrun` is set and the buffer holds the newer character.
- R8: `err_parity`, `err_frame` and `err_overrun` stay set, including across buffer reads, until `err_clr` is sampled high.
- R9: A low pulse on the line that is shorter than half a bit is rejected: the receiver goes back to idle and no character, flag or error results.
- R10: `brk_det` is set when the stop bit of a character is sampled low and the stop bit of the character just before it was also sampled low, with no high line between them. One low stop bit alone does not set it.
- R11: `brk_det` clears within three ticks of the serial input returning high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; one tick per oversample |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial input line, idle high |
| fac_sel | input | 2 | Rate factor code (bit = 4 << code ticks) |
| len_sel | input | 2 | Data length code (5 + code bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Host read of the receive buffer |
| err_clr | input | 1 | Clears the three error flags |
| rx_data | output | 8 | Received character, right aligned |
| rx_ready | output | 1 | Character waiting to be read |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| brk_det | output | 1 | Break condition on the line |

## Verification
The main deframing path is driven by a table of characters that covers:

- every rate factor and every data length
- parity off, even and odd
- correct and corrupted parity bits
- correct and low stop bits

These vectors tell apart timing errors, bit ordering and length masking, the parity sense, and whether each error flag follows only its own cause. Directed patterns then exercise the remaining behaviours:

- Two unread characters in a row separate overrun from plain readiness.
- A short low glitch checks that false starts are rejected.
- A line held low for one frame and then for several frames shows that break needs two consecutive low stop bits and drops as soon as the line returns high.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_TAIL
  } rx_state_e;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign d_out = sh_q[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign hit = (cnt_q == limit);

  always_comb begin
    if (clr || hit) cnt_d = '0;
    else            cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import async_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BASE_SHIFT = 2,
  parameter int CNT_W      = BASE_SHIFT + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_s,
  input  logic [1:0]        fac_sel,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              tmr_hit,
  output logic              tmr_clr,
  output logic [CNT_W-1:0]  tmr_limit,
  output logic              chr_done,
  output logic [DATA_W-1:0] chr_data,
  output logic              chr_par_bad,
  output logic              chr_stop_low
);

  localparam int IDX_W    = $clog2(DATA_W);
  localparam int LEN_BASE = DATA_W - 4;

  rx_state_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              acc_q, acc_d;
  logic              pbad_q, pbad_d;

  logic [CNT_W-1:0]  bit_len;
  logic [IDX_W-1:0]  last_idx;

  assign bit_len   = CNT_W'(1) << (BASE_SHIFT + int'(fac_sel));
  assign last_idx  = IDX_W'(LEN_BASE) + IDX_W'(len_sel);
  assign tmr_limit = ((st_q == ST_START) || (st_q == ST_TAIL))
                     ? ((bit_len >> 1) - CNT_W'(1))
                     : (bit_len - CNT_W'(1));
  assign tmr_clr   = (st_q == ST_IDLE);

  always_comb begin
    st_d         = st_q;
    idx_d        = idx_q;
    dat_d        = dat_q;
    acc_d        = acc_q;
    pbad_d       = pbad_q;
    chr_done     = 1'b0;
    chr_stop_low = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!rx_s) st_d = ST_START;
      end
      ST_START: begin
        if (tmr_hit) begin
          if (rx_s) begin
            st_d = ST_IDLE;
          end else begin
            st_d   = ST_DATA;
            idx_d  = '0;
            dat_d  = '0;
            acc_d  = 1'b0;
            pbad_d = 1'b0;
          end
        end
      end
      ST_DATA: begin
        if (tmr_hit) begin
          dat_d[idx_q] = rx_s;
          acc_d        = acc_q ^ rx_s;
          idx_d        = idx_q + IDX_W'(1);
          if (idx_q == last_idx) st_d = par_en ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR: begin
        if (tmr_hit) begin
          pbad_d = acc_q ^ rx_s ^ par_odd;
          st_d   = ST_STOP;
        end
      end
      ST_STOP: begin
        if (tmr_hit) begin
          chr_done     = 1'b1;
          chr_stop_low = !rx_s;
          st_d         = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (tmr_hit) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign chr_data    = dat_q;
  assign chr_par_bad = pbad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      dat_q  <= '0;
      acc_q  <= 1'b0;
      pbad_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      dat_q  <= dat_d;
      acc_q  <= acc_d;
      pbad_q <= pbad_d;
    end
  end

endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_s,
  input  logic              chr_done,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              chr_par_bad,
  input  logic              chr_stop_low,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              brk_det
);

  logic [DATA_W-1:0] buf_q, buf_d;
  logic rdy_q, rdy_d;
  logic pe_q, pe_d, fe_q, fe_d, oe_q, oe_d;
  logic brk_q, brk_d, prev_low_q, prev_low_d;
  logic buf_en;

  assign buf_en = chr_done;

  always_comb begin
    buf_d = buf_q;
    if (buf_en) buf_d = chr_data;

    rdy_d = rdy_q;
    if (rd_strobe) rdy_d = 1'b0;
    if (chr_done)  rdy_d = 1'b1;

    pe_d = pe_q;
    fe_d = fe_q;
    oe_d = oe_q;
    if (err_clr) begin
      pe_d = 1'b0;
      fe_d = 1'b0;
      oe_d = 1'b0;
    end
    if (chr_done && chr_par_bad)           pe_d = 1'b1;
    if (chr_done && chr_stop_low)          fe_d = 1'b1;
    if (chr_done && rdy_q && !rd_strobe)   oe_d = 1'b1;

    prev_low_d = prev_low_q;
    brk_d      = brk_q;
    if (rx_s) begin
      prev_low_d = 1'b0;
      brk_d      = 1'b0;
    end else if (chr_done) begin
      prev_low_d = chr_stop_low;
      if (chr_stop_low && prev_low_q) brk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q      <= '0;
      rdy_q      <= 1'b0;
      pe_q       <= 1'b0;
      fe_q       <= 1'b0;
      oe_q       <= 1'b0;
      brk_q      <= 1'b0;
      prev_low_q <= 1'b0;
    end else begin
      buf_q      <= buf_d;
      rdy_q      <= rdy_d;
      pe_q       <= pe_d;
      fe_q       <= fe_d;
      oe_q       <= oe_d;
      brk_q      <= brk_d;
      prev_low_q <= prev_low_d;
    end
  end

  assign rx_data     = buf_q;
  assign rx_ready    = rdy_q;
  assign err_parity  = pe_q;
  assign err_frame   = fe_q;
  assign err_overrun = oe_q;
  assign brk_det     = brk_q;

endmodule

// File: rtl/async_rx_brk.sv
module async_rx_brk #(
  parameter int DATA_W      = 8,
  parameter int BASE_SHIFT  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic [1:0]        fac_sel,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              brk_det
);

  localparam int CNT_W = BASE_SHIFT + 4;

  logic              rx_s;
  logic              tmr_clr;
  logic              tmr_hit;
  logic [CNT_W-1:0]  tmr_limit;
  logic              chr_done;
  logic [DATA_W-1:0] chr_data;
  logic              chr_par_bad;
  logic              chr_stop_low;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (rx_in),
    .d_out (rx_s)
  );

  rx_bit_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .limit (tmr_limit),
    .hit   (tmr_hit)
  );

  rx_deframer #(
    .DATA_W     (DATA_W),
    .BASE_SHIFT (BASE_SHIFT),
    .CNT_W      (CNT_W)
  ) u_dfr (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_s         (rx_s),
    .fac_sel      (fac_sel),
    .len_sel      (len_sel),
    .par_en       (par_en),
    .par_odd      (par_odd),
    .tmr_hit      (tmr_hit),
    .tmr_clr      (tmr_clr),
    .tmr_limit    (tmr_limit),
    .chr_done     (chr_done),
    .chr_data     (chr_data),
    .chr_par_bad  (chr_par_bad),
    .chr_stop_low (chr_stop_low)
  );

  rx_status #(.DATA_W(DATA_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_s         (rx_s),
    .chr_done     (chr_done),
    .chr_data     (chr_data),
    .chr_par_bad  (chr_par_bad),
    .chr_stop_low (chr_stop_low),
    .rd_strobe    (rd_strobe),
    .err_clr      (err_clr),
    .rx_data      (rx_data),
    .rx_ready     (rx_ready),
    .err_parity   (err_parity),
    .err_frame    (err_frame),
    .err_overrun  (err_overrun),
    .brk_det      (brk_det)
  );

endmodule

// File: rtl/async_rx_brk_chk.sv
module async_rx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_s,
  input logic chr_done,
  input logic chr_stop_low,
  input logic chr_par_bad,
  input logic rd_strobe,
  input logic err_clr,
  input logic rx_ready,
  input logic err_parity,
  input logic err_frame,
  input logic err_overrun,
  input logic brk_det
);

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !chr_done) |=> !rx_ready); // R6

  AST_READY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(chr_done)); // R6

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && rx_ready && !rd_strobe) |=> err_overrun); // R7

  AST_FRAME_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && chr_stop_low) |=> err_frame); // R5

  AST_PARITY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && chr_par_bad) |=> err_parity); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !err_clr) |=> err_frame); // R8

  AST_BREAK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> $past(chr_done && chr_stop_low)); // R10

  AST_BREAK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_s |=> !brk_det); // R11

endmodule

bind async_rx_brk async_rx_brk_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_s         (rx_s),
  .chr_done     (chr_done),
  .chr_stop_low (chr_stop_low),
  .chr_par_bad  (chr_par_bad),
  .rd_strobe    (rd_strobe),
  .err_clr      (err_clr),
  .rx_ready     (rx_ready),
  .err_parity   (err_parity),
  .err_frame    (err_frame),
  .err_overrun  (err_overrun),
  .brk_det      (brk_det)
);

// File: tb/sim_async_rx_brk.sv
module sim_async_rx_brk;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] fac;
    logic [1:0] len;
    logic       pen;
    logic       podd;
    logic [7:0] dat;
    logic       bad_par;
    logic       bad_stop;
    logic [7:0] exp_dat;
    logic       exp_pe;
    logic       exp_fe;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TBL [NVEC] = '{
    '{2'd0, 2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    '{2'd2, 2'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    '{2'd1, 2'd2, 1'b1, 1'b0, 8'h53, 1'b0, 1'b0, 8'h53, 1'b0, 1'b0},
    '{2'd1, 2'd3, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0},
    '{2'd3, 2'd1, 1'b1, 1'b0, 8'h2A, 1'b1, 1'b0, 8'h2A, 1'b1, 1'b0},
    '{2'd0, 2'd3, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1},
    '{2'd2, 2'd3, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    '{2'd0, 2'd2, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b1, 8'h7F, 1'b1, 1'b1}
  };

  logic       clk;
  logic       rst_n;
  logic       rx_in;
  logic [1:0] fac_sel;
  logic [1:0] len_sel;
  logic       par_en;
  logic       par_odd;
  logic       rd_strobe;
  logic       err_clr;
  logic [7:0] rx_data;
  logic       rx_ready;
  logic       err_parity;
  logic       err_frame;
  logic       err_overrun;
  logic       brk_det;

  int n_chk;
  int n_fail;

  async_rx_brk u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_in       (rx_in),
    .fac_sel     (fac_sel),
    .len_sel     (len_sel),
    .par_en      (par_en),
    .par_odd     (par_odd),
    .rd_strobe   (rd_strobe),
    .err_clr     (err_clr),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_overrun (err_overrun),
    .brk_det     (brk_det)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    @(negedge clk);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [1:0] fac, input logic [1:0] len,
                            input logic pen, input logic podd, input logic [7:0] dat,
                            input logic bad_par, input logic bad_stop);
    int f;
    int nb;
    logic par;
    f   = 4 << fac;
    nb  = 5 + int'(len);
    par = podd ^ bad_par;
    rx_in = 1'b0;
    tick(f);
    for (int i = 0; i < nb; i++) begin
      rx_in = dat[i];
      par   = par ^ dat[i];
      tick(f);
    end
    if (pen) begin
      rx_in = par;
      tick(f);
    end
    rx_in = !bad_stop;
    tick(f);
    rx_in = 1'b1;
    tick(2 * f);
  endtask

  task automatic host_read();
    rd_strobe = 1'b1;
    tick(1);
    rd_strobe = 1'b0;
  endtask

  task automatic host_clear();
    err_clr = 1'b1;
    tick(1);
    err_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    vec_t v;
    n_chk     = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    rx_in     = 1'b1;
    fac_sel   = 2'd0;
    len_sel   = 2'd3;
    par_en    = 1'b0;
    par_odd   = 1'b0;
    rd_strobe = 1'b0;
    err_clr   = 1'b0;
    tick(3);
    check("R1 ready in reset", rx_ready, 0);
    check("R1 flags in reset", {err_parity, err_frame, err_overrun, brk_det}, 0);
    rst_n = 1'b1;
    tick(5);
    check("R1 ready after reset", rx_ready, 0);
    check("R1 flags after reset", {err_parity, err_frame, err_overrun, brk_det}, 0);

    for (int k = 0; k < NVEC; k++) begin
      v       = TBL[k];
      fac_sel = v.fac;
      len_sel = v.len;
      par_en  = v.pen;
      par_odd = v.podd;
      tick(2);
      send_frame(v.fac, v.len, v.pen, v.podd, v.dat, v.bad_par, v.bad_stop);
      check("R2 R3 R6 ready after frame", rx_ready, 1);
      check("R2 R3 data", rx_data, v.exp_dat);
      check("R4 parity flag", err_parity, v.exp_pe);
      check("R5 frame flag", err_frame, v.exp_fe);
      check("R7 no overrun", err_overrun, 0);
      check("R10 single frame no break", brk_det, 0);
      host_read();
      check("R6 ready cleared by read", rx_ready, 0);
      check("R8 flags kept over read", {err_parity, err_frame}, {v.exp_pe, v.exp_fe});
      host_clear();
      check("R8 flags cleared", {err_parity, err_frame, err_overrun}, 0);
    end

    // Overrun: two characters without a read
    fac_sel = 2'd0; len_sel = 2'd3; par_en = 1'b0;
    tick(2);
    send_frame(2'd0, 2'd3, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0);
    check("R7 first char no overrun", err_overrun, 0);
    send_frame(2'd0, 2'd3, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0);
    check("R7 overrun set", err_overrun, 1);
    check("R7 newer char kept", rx_data, 8'h22);
    host_read();
    check("R6 ready cleared", rx_ready, 0);
    check("R8 overrun sticky", err_overrun, 1);
    host_clear();
    check("R8 overrun cleared", err_overrun, 0);

    // Short glitch rejected
    fac_sel = 2'd2;
    tick(2);
    rx_in = 1'b0;
    tick(4);
    rx_in = 1'b1;
    tick(16 * 14);
    check("R9 glitch gives no char", rx_ready, 0);
    check("R9 glitch gives no error", {err_parity, err_frame, err_overrun}, 0);

    // Break: line held low
    fac_sel = 2'd0; len_sel = 2'd3; par_en = 1'b0;
    tick(2);
    rx_in = 1'b0;
    tick(60);
    check("R10 one low stop no break", brk_det, 0);
    check("R5 frame flag on low stop", err_frame, 1);
    tick(60);
    check("R10 break after two low stops", brk_det, 1);
    rx_in = 1'b1;
    tick(3);
    check("R11 break cleared by high line", brk_det, 0);
    tick(4 * 15);
    host_read();
    host_clear();
    check("R8 all cleared after break", {err_parity, err_frame, err_overrun, brk_det}, 0);

    finish_run();
  end

endmodule